// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block drives the command pins of a single-data-rate SDRAM from a host-written command port. The pins it drives are clock enable, chip select, the row strobe, the column strobe, write enable, bank address and address. Each accepted write launches one command. The mode field picks the command: clock enable, precharge of all banks, a run of auto-refreshes, or a load of the device mode register. The block then holds `busy` high for the programmed spacing before it accepts the next command. The host performs device initialization step by step: turn the clock on, wait at least 100 us, precharge all, run eight auto-refreshes, load the mode register, then program the refresh interval.

The spacings are taken from live configuration inputs. Each is coded as a cycle count minus one, so a field value of 2 means three cycles. Precharge uses tRP, every auto-refresh uses tRC, and the mode-register load uses tMRD. Once the mode register has been loaded and a nonzero refresh interval has been programmed, a free-running timer asks for one auto-refresh per period. If a period ends while the previous request is still waiting, a sticky refresh-error flag is set. The host clears that flag by writing one to it, and an enable input lets the flag raise an interrupt.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is held, clock enable is low, chip select is high, the row strobe, column strobe and write enable are high, and `busy`, `overrun`, `refErr` and `refIrq` are low.
- R2: Mode 1 sets clock enable high. Clock enable then stays high until reset. The command pins keep showing NOP, and `busy` is high for exactly one cycle.
- R3: Mode 2 drives one precharge-all cycle: row strobe low, column strobe high, write enable low, address bit 10 high. `busy` stays high for tRP+1 cycles, counted from that command cycle.
- R4: Mode 3 with repeat field n drives n+1 auto-refresh cycles (row strobe low, column strobe low, write enable high). Consecutive refreshes start tRC+1 cycles apart, and `busy` stays high for (n+1)(tRC+1) cycles.
- R5: Mode 4 drives one load-mode-register cycle with all three strobes low, bank address 0 and the payload on the address bus. `busy` stays high for tMRD+1 cycles. The payload layout is: burst length in bits 2:0, burst type in bit 3, CAS latency in bits 6:4, operating mode in bits 8:7, write-burst mode in bit 9. CL2 with burst length 1, sequential bursts and standard operation therefore gives 0x020.
- R6: After reset, chip select is low on every cycle. Every cycle that carries no command shows NOP, which means all three strobes are high.
- R7: A write received while `busy` is high is ignored and sets the sticky `overrun` flag.
- R8: A write with the target bit at 0, or with mode 0, 5, 6 or 7, is ignored. It drives no command, does not raise `busy` and does not set `overrun`.
- R9: Periodic refreshes start only after a mode-register load and a nonzero interval value v. With the host idle and a short tRC, timer-driven refreshes occur exactly v+1 cycles apart. A host write and a pending timer refresh arriving in the same idle cycle are resolved in favour of the host.
- R10: `refErr` is set when the timer expires while an earlier request is still pending, and it stays set until `errClear` is pulsed. `refIrq` is high exactly when `refErr` and `errIrqEn` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM-side clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWrite | input | 1 | Command write strobe |
| cmdMode | input | 3 | Command select (1 clock on, 2 precharge all, 3 refresh, 4 mode load) |
| cmdTarget | input | 1 | Target device bit; a command runs only when it is 1 |
| cmdRepeat | input | 4 | Auto-refresh count minus one |
| cmdPayload | input | 13 | Mode-register value |
| tMrdCfg | input | 4 | tMRD cycles minus one |
| tRpCfg | input | 4 | tRP cycles minus one |
| tRcCfg | input | 4 | tRC cycles minus one |
| refLoad | input | 1 | Load strobe for the refresh interval |
| refReload | input | 13 | Refresh interval value (period is value+1; 0 stops the timer) |
| errClear | input | 1 | Write-one-to-clear for the refresh error |
| errIrqEn | input | 1 | Interrupt enable for the refresh error |
| sdCke | output | 1 | Clock enable |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | 2 | Bank address |
| sdAddr | output | 13 | Address bus |
| busy | output | 1 | Command in progress |
| overrun | output | 1 | Sticky: a write arrived while busy |
| refErr | output | 1 | Sticky refresh error |
| refIrq | output | 1 | Refresh error interrupt |

## Verification
The directed part first runs the full host sequence once with fixed spacings. It then adds writes that must be ignored, which separates the command decode from the validity gating, and a write placed during a long precharge, which exposes the busy gating. The random part varies tRP, tRC, tMRD, the refresh repeat count and the mode payload from one run to the next. This catches spacing or count errors that a single fixed setting would hide. Two timer runs then tell a correct period apart from an off-by-one reload, and a starved refresh (tRC longer than the period) apart from normal servicing.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  localparam logic [2:0] MODE_CKE = 3'd1;
  localparam logic [2:0] MODE_PRE = 3'd2;
  localparam logic [2:0] MODE_REF = 3'd3;
  localparam logic [2:0] MODE_LMR = 3'd4;

  // one-cycle command strobes from control to the pin datapath
  typedef struct packed {
    logic doCke;
    logic doPre;
    logic doRef;
    logic doLmr;
  } seqStrobe_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_GAP = 1'b1} seqState_t;

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int REF_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [REF_W-1:0] reloadIn,
  input  logic             initDone,
  input  logic             ack,
  input  logic             errClear,
  output logic             pending,
  output logic             err
);
  logic [REF_W-1:0] reloadVal;
  logic [REF_W-1:0] cnt;
  logic             enable;
  logic             expire;

  assign enable = initDone && (reloadVal != '0);
  assign expire = enable && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= '0;
      cnt       <= '0;
    end else if (load) begin
      reloadVal <= reloadIn;
      cnt       <= reloadIn;
    end else if (enable) begin
      cnt <= (cnt == '0) ? reloadVal : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (expire)   pending <= 1'b1;
      else if (ack) pending <= 1'b0;
      if (expire && pending && !ack) err <= 1'b1;
      else if (errClear)             err <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int TIM_W  = 4,
  parameter int RCNT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  logic [2:0]        cmdMode,
  input  logic              cmdTarget,
  input  logic [RCNT_W-1:0] cmdRepeat,
  input  logic [TIM_W-1:0]  tMrdCfg,
  input  logic [TIM_W-1:0]  tRpCfg,
  input  logic [TIM_W-1:0]  tRcCfg,
  input  logic              refPending,
  output seqStrobe_t        strobe,
  output logic              refAck,
  output logic              busy,
  output logic              overrun,
  output logic              initDone
);
  seqState_t         state;
  logic [TIM_W-1:0]  gapCnt;
  logic [RCNT_W-1:0] repLeft;
  logic              modeValid;
  logic              hostAccept;
  logic              launch;
  logic [TIM_W-1:0]  nextGap;
  logic [RCNT_W-1:0] nextRep;

  assign busy       = (state == ST_GAP);
  assign modeValid  = (cmdMode >= MODE_CKE) && (cmdMode <= MODE_LMR);
  assign hostAccept = !busy && cmdWrite && cmdTarget && modeValid;

  always_comb begin
    strobe  = '0;
    refAck  = 1'b0;
    launch  = 1'b0;
    nextGap = '0;
    nextRep = '0;
    if (state == ST_IDLE) begin
      if (hostAccept) begin
        launch = 1'b1;
        unique case (cmdMode)
          MODE_CKE: strobe.doCke = 1'b1;
          MODE_PRE: begin strobe.doPre = 1'b1; nextGap = tRpCfg; end
          MODE_REF: begin strobe.doRef = 1'b1; nextGap = tRcCfg; nextRep = cmdRepeat; end
          default:  begin strobe.doLmr = 1'b1; nextGap = tMrdCfg; end
        endcase
      end else if (refPending) begin
        launch       = 1'b1;
        refAck       = 1'b1;
        strobe.doRef = 1'b1;
        nextGap      = tRcCfg;
      end
    end else if (gapCnt == '0 && repLeft != '0) begin
      strobe.doRef = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      gapCnt   <= '0;
      repLeft  <= '0;
      overrun  <= 1'b0;
      initDone <= 1'b0;
    end else begin
      if (cmdWrite && busy) overrun <= 1'b1;
      if (strobe.doLmr)     initDone <= 1'b1;
      if (launch) begin
        state   <= ST_GAP;
        gapCnt  <= nextGap;
        repLeft <= nextRep;
      end else if (state == ST_GAP) begin
        if (gapCnt != '0) begin
          gapCnt <= gapCnt - 1'b1;
        end else if (repLeft != '0) begin
          repLeft <= repLeft - 1'b1;
          gapCnt  <= tRcCfg;
        end else begin
          state <= ST_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/sdram_seq_dp.sv
module sdram_seq_dp
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] payload,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BA_W-1:0]   sdBa,
  output logic [ADDR_W-1:0] sdAddr
);
  localparam int AP_BIT = 10;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdCke  <= 1'b0;
      sdCsN  <= 1'b1;
      sdRasN <= 1'b1;
      sdCasN <= 1'b1;
      sdWeN  <= 1'b1;
      sdBa   <= '0;
      sdAddr <= '0;
    end else begin
      sdCsN  <= 1'b0;
      sdRasN <= 1'b1;
      sdCasN <= 1'b1;
      sdWeN  <= 1'b1;
      sdBa   <= '0;
      sdAddr <= '0;
      if (strobe.doCke) sdCke <= 1'b1;
      if (strobe.doPre) begin
        sdRasN         <= 1'b0;
        sdWeN          <= 1'b0;
        sdAddr[AP_BIT] <= 1'b1;
      end
      if (strobe.doRef) begin
        sdRasN <= 1'b0;
        sdCasN <= 1'b0;
      end
      if (strobe.doLmr) begin
        sdRasN <= 1'b0;
        sdCasN <= 1'b0;
        sdWeN  <= 1'b0;
        sdAddr <= payload;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int TIM_W  = 4,
  parameter int RCNT_W = 4,
  parameter int REF_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  logic [2:0]        cmdMode,
  input  logic              cmdTarget,
  input  logic [RCNT_W-1:0] cmdRepeat,
  input  logic [ADDR_W-1:0] cmdPayload,
  input  logic [TIM_W-1:0]  tMrdCfg,
  input  logic [TIM_W-1:0]  tRpCfg,
  input  logic [TIM_W-1:0]  tRcCfg,
  input  logic              refLoad,
  input  logic [REF_W-1:0]  refReload,
  input  logic              errClear,
  input  logic              errIrqEn,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BA_W-1:0]   sdBa,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              busy,
  output logic              overrun,
  output logic              refErr,
  output logic              refIrq
);
  seqStrobe_t strobe;
  logic       refPending;
  logic       refAck;
  logic       initDone;

  sdram_seq_ctrl #(.TIM_W(TIM_W), .RCNT_W(RCNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdMode(cmdMode),
    .cmdTarget(cmdTarget), .cmdRepeat(cmdRepeat), .tMrdCfg(tMrdCfg),
    .tRpCfg(tRpCfg), .tRcCfg(tRcCfg), .refPending(refPending),
    .strobe(strobe), .refAck(refAck), .busy(busy), .overrun(overrun),
    .initDone(initDone)
  );

  sdram_seq_dp #(.ADDR_W(ADDR_W), .BA_W(BA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .payload(cmdPayload),
    .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
    .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr)
  );

  sdram_refresh_timer #(.REF_W(REF_W)) uTimer (
    .clk(clk), .rstN(rstN), .load(refLoad), .reloadIn(refReload),
    .initDone(initDone), .ack(refAck), .errClear(errClear),
    .pending(refPending), .err(refErr)
  );

  assign refIrq = refErr && errIrqEn;
endmodule

// File: rtl/sdram_seq_checker.sv
module sdram_seq_checker #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWrite,
  input logic              errClear,
  input logic              errIrqEn,
  input logic              sdCke,
  input logic              sdRasN,
  input logic              sdCasN,
  input logic              sdWeN,
  input logic [BA_W-1:0]   sdBa,
  input logic [ADDR_W-1:0] sdAddr,
  input logic              busy,
  input logic              overrun,
  input logic              refErr,
  input logic              refIrq
);
  logic isNop, isPre, isLmr;
  assign isNop = sdRasN && sdCasN && sdWeN;
  assign isPre = !sdRasN && sdCasN && !sdWeN;
  assign isLmr = !sdRasN && !sdCasN && !sdWeN;

  AST_NOP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN) !busy |-> isNop); // R6
  AST_CMD_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN) !isNop |-> busy); // R4
  AST_PRE_A10_HIGH: assert property (@(posedge clk) disable iff (!rstN) isPre |-> sdAddr[10]); // R3
  AST_LMR_BANK_ZERO: assert property (@(posedge clk) disable iff (!rstN) isLmr |-> (sdBa == '0)); // R5
  AST_CKE_HOLDS: assert property (@(posedge clk) disable iff (!rstN) sdCke |=> sdCke); // R2
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN) overrun |=> overrun); // R7
  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN) (busy && cmdWrite) |=> overrun); // R7
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rstN) (refErr && !errClear) |=> refErr); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN) !errIrqEn |-> !refIrq); // R10
endmodule

bind sdram_cmd_seq sdram_seq_checker #(.ADDR_W(ADDR_W), .BA_W(BA_W)) uChk (
  .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .errClear(errClear),
  .errIrqEn(errIrqEn), .sdCke(sdCke), .sdRasN(sdRasN), .sdCasN(sdCasN),
  .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr), .busy(busy),
  .overrun(overrun), .refErr(refErr), .refIrq(refIrq)
);

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrite = 1'b0;
  logic [2:0]  cmdMode = '0;
  logic        cmdTarget = 1'b0;
  logic [3:0]  cmdRepeat = '0;
  logic [12:0] cmdPayload = '0;
  logic [3:0]  tMrdCfg = 4'd1, tRpCfg = 4'd2, tRcCfg = 4'd5;
  logic        refLoad = 1'b0;
  logic [12:0] refReload = '0;
  logic        errClear = 1'b0, errIrqEn = 1'b0;
  logic        sdCke, sdCsN, sdRasN, sdCasN, sdWeN;
  logic [1:0]  sdBa;
  logic [12:0] sdAddr;
  logic        busy, overrun, refErr, refIrq;

  sdram_cmd_seq dut (.*);

  always #5 clk = ~clk;

  int nChecks = 0, nErr = 0, cyc = 0;
  int evN = 0, busyCnt = 0;
  int evCyc[256];
  logic [2:0]  evKind[256];
  logic [12:0] evAddr[256];
  logic [1:0]  evBa[256];
  bit done = 0;

  localparam logic [2:0] K_PRE = 3'b010, K_REF = 3'b001, K_LMR = 3'b000;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rstN) begin
    if (busy) busyCnt++;
    if (!(sdRasN && sdCasN && sdWeN) && evN < 256) begin
      evKind[evN] = {sdRasN, sdCasN, sdWeN};
      evCyc[evN]  = cyc;
      evAddr[evN] = sdAddr;
      evBa[evN]   = sdBa;
      evN++;
    end
  end

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [12:0] mkPayload(int bl, int bt, int cl, int om, int wb);
    return 13'((bl & 7) | ((bt & 1) << 3) | ((cl & 7) << 4) | ((om & 3) << 7) | ((wb & 1) << 9));
  endfunction

  function automatic int expBusy(int mode, int rep, int mrd, int rp, int rc);
    case (mode)
      1: return 1;
      2: return rp + 1;
      3: return (rep + 1) * (rc + 1);
      4: return mrd + 1;
      default: return 0;
    endcase
  endfunction

  task automatic clearLog();
    @(posedge clk); #1;
    evN = 0; busyCnt = 0;
  endtask

  task automatic hostCmd(int mode, bit tgt, int rep, logic [12:0] pl);
    @(negedge clk);
    cmdWrite = 1'b1; cmdMode = 3'(mode); cmdTarget = tgt;
    cmdRepeat = 4'(rep); cmdPayload = pl;
    @(negedge clk);
    cmdWrite = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic loadTimer(int v);
    @(negedge clk); refLoad = 1'b1; refReload = 13'(v);
    @(negedge clk); refLoad = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    int seedDummy;
    int ok;
    seedDummy = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cke", sdCke, 0);
    chk("R1 csN", sdCsN, 1);
    chk("R1 strobes", {sdRasN, sdCasN, sdWeN}, 7);
    chk("R1 flags", {busy, overrun, refErr, refIrq}, 0);
    @(negedge clk) rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 csN low", sdCsN, 0);

    // R8 ignored writes
    clearLog();
    hostCmd(2, 1'b0, 0, '0);
    hostCmd(6, 1'b1, 0, '0);
    hostCmd(0, 1'b1, 0, '0);
    repeat (4) @(negedge clk);
    chk("R8 no command", evN, 0);
    chk("R8 no busy", busyCnt, 0);
    chk("R8 no overrun", overrun, 0);

    // R9 timer idle before mode load
    loadTimer(20);
    clearLog();
    repeat (60) @(negedge clk);
    chk("R9 no refresh before init", evN, 0);
    loadTimer(0);

    // R2 clock enable
    clearLog();
    hostCmd(1, 1'b1, 0, '0);
    chk("R2 busy during", busy, 1);
    @(negedge clk);
    chk("R2 busy one cycle", busy, 0);
    chk("R2 cke high", sdCke, 1);
    chk("R2 nop only", evN, 0);
    repeat (20) @(negedge clk);

    // R3 precharge all
    clearLog();
    hostCmd(2, 1'b1, 0, '0);
    waitIdle();
    chk("R3 count", evN, 1);
    chk("R3 kind", evKind[0], K_PRE);
    chk("R3 A10", evAddr[0][10], 1);
    chk("R3 busy length", busyCnt, expBusy(2, 0, tMrdCfg, tRpCfg, tRcCfg));

    // R4 eight refreshes
    clearLog();
    hostCmd(3, 1'b1, 7, '0);
    waitIdle();
    chk("R4 count", evN, 8);
    ok = 1;
    for (int i = 1; i < evN; i++)
      if (evCyc[i] - evCyc[i-1] != int'(tRcCfg) + 1 || evKind[i] != K_REF) ok = 0;
    chk("R4 spacing", ok, 1);
    chk("R4 busy length", busyCnt, expBusy(3, 7, tMrdCfg, tRpCfg, tRcCfg));

    // R5 mode register load, CL2 BL1 sequential
    clearLog();
    hostCmd(4, 1'b1, 0, mkPayload(0, 0, 2, 0, 0));
    waitIdle();
    chk("R5 count", evN, 1);
    chk("R5 kind", evKind[0], K_LMR);
    chk("R5 payload", evAddr[0], 13'h020);
    chk("R5 bank", evBa[0], 0);
    chk("R5 busy length", busyCnt, expBusy(4, 0, tMrdCfg, tRpCfg, tRcCfg));

    // random commands with random spacings (R3 R4 R5)
    for (int it = 0; it < 30; it++) begin
      int mode, rep;
      logic [12:0] pl;
      mode = 2 + int'($urandom % 3);
      rep  = int'($urandom % 16);
      pl   = 13'($urandom % 1024);
      @(negedge clk);
      tMrdCfg = 4'($urandom % 8); tRpCfg = 4'($urandom % 8); tRcCfg = 4'($urandom % 8);
      clearLog();
      hostCmd(mode, 1'b1, rep, pl);
      waitIdle();
      chk("R3R4R5 busy length", busyCnt, expBusy(mode, rep, tMrdCfg, tRpCfg, tRcCfg));
      if (mode == 3) begin
        chk("R4 random count", evN, rep + 1);
        ok = 1;
        for (int i = 1; i < evN; i++)
          if (evCyc[i] - evCyc[i-1] != int'(tRcCfg) + 1) ok = 0;
        chk("R4 random spacing", ok, 1);
      end else if (mode == 2) begin
        chk("R3 random kind", evKind[0], K_PRE);
      end else begin
        chk("R5 random payload", evAddr[0], pl);
      end
    end

    // R7 write during busy
    @(negedge clk); tRpCfg = 4'd10;
    clearLog();
    hostCmd(2, 1'b1, 0, '0);
    hostCmd(4, 1'b1, 0, 13'h020);
    waitIdle();
    chk("R7 single command", evN, 1);
    chk("R7 overrun", overrun, 1);
    repeat (5) @(negedge clk);
    chk("R7 overrun sticky", overrun, 1);

    // R9 periodic refresh
    @(negedge clk); tRcCfg = 4'd3;
    loadTimer(30);
    clearLog();
    repeat (200) @(negedge clk);
    chk("R9 enough refreshes", int'(evN >= 5), 1);
    ok = 1;
    for (int i = 1; i < evN; i++)
      if (evCyc[i] - evCyc[i-1] != 31 || evKind[i] != K_REF) ok = 0;
    chk("R9 period", ok, 1);
    chk("R10 no error", refErr, 0);

    // R10 starved refresh
    @(negedge clk); tRcCfg = 4'd15;
    loadTimer(4);
    repeat (60) @(negedge clk);
    chk("R10 error set", refErr, 1);
    chk("R10 irq masked", refIrq, 0);
    errIrqEn = 1'b1; #1;
    chk("R10 irq raised", refIrq, 1);
    loadTimer(0);
    repeat (40) @(negedge clk);
    chk("R10 error held", refErr, 1);
    errClear = 1'b1;
    @(negedge clk); errClear = 1'b0;
    chk("R10 error cleared", refErr, 0);
    chk("R10 irq cleared", refIrq, 0);

    finishRun();
  end
endmodule